// File: doc/BRIEF.md
# Data-Cache Maintenance Controller

This block runs maintenance on the valid, dirty and tag state of a small set-associative data cache. Software drives it through a narrow register bus. Writing a line address to one of two command registers invalidates or flushes the single line that holds that address. Writing 1 to one of two whole-cache registers walks every line of the array. An invalidate either discards the line or writes a dirty line back first. A mode bit in the control register picks which. A flush writes dirty lines back and leaves them valid. Dirty lines leave through a request/acknowledge writeback port.

The same control register has a disable bit and a read-only flush-in-progress bit, which software polls. A fill port stands in for the normal allocation path. A probe port stands in for the lookup path, so the effect of each operation on the array can be observed. The default geometry is 4 ways, 64 sets and 32-byte lines. The build has one virtual-index bit, carried in the line-offset field of command addresses.

Top module: `dcache_maint_ctrl`

## Requirements
- R1: After reset every line is invalid, the control register reads 0, `wb_req` is low and `probe_hit` is low.
- R2: The control register is at bus select 0. Bit 0 is disable, bit 1 is invalidate mode (0 = discard, 1 = write back then discard) and bit 2 is flush-busy. Bit 2 is read-only, and writes to it are ignored. `cache_en` equals the inverse of bit 0.
- R3: Line commands take the tag from address bits [31:11] and the set from {bit 0, bits [9:5]}. Bits [4:1] and bit 10 are ignored.
- R4: Select 1 (line invalidate) in mode 0 drops the valid, tag-matching line without any writeback. All other lines are untouched.
- R5: Select 1 in mode 1 writes a dirty matching line back and then drops it. A clean matching line is dropped with no writeback.
- R6: Select 2 (line flush) writes a dirty matching line back and clears its dirty bit, and the line stays valid. A clean or absent line causes no writeback.
- R7: Select 3 (whole invalidate) drops every line and follows the mode bit. Writebacks come out in ascending set order, and ascending way order within a set.
- R8: Select 4 (whole flush) writes back every dirty line in the same order and leaves all lines valid. A second whole flush right after produces no writeback.
- R9: Flush-busy reads 1 while a flush or write-back-invalidate is running, and reads 0 once it completes.
- R10: While any operation runs, `aux_stall` is high and bus writes are not taken. This includes control writes. Reads are still answered.
- R11: `wb_req` stays high with a stable `wb_addr` = {tag, set, 5'b0} until `wb_ack`. Each written-back line gives exactly one request.
- R12: While disabled, `probe_hit` is 0 and fills are ignored. Fills are also ignored while an operation runs.
- R13: Selects 3 and 4 start an operation only when bit 0 of the written data is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_wr | input | 1 | Register write strobe |
| aux_rd | input | 1 | Register read strobe |
| aux_addr | input | 3 | Register select |
| aux_wdata | input | ADDR_W | Write data / command address |
| aux_rdata | output | ADDR_W | Read data (control register) |
| aux_stall | output | 1 | Write not taken, operation in progress |
| cache_en | output | 1 | Cache enabled |
| fill_en | input | 1 | Allocate a line |
| fill_set | input | IDX_W | Allocate set |
| fill_way | input | WAY_W | Allocate way |
| fill_tag | input | TAG_W | Allocate tag |
| fill_dirty | input | 1 | Allocated line is dirty |
| probe_set | input | IDX_W | Lookup set |
| probe_tag | input | TAG_W | Lookup tag |
| probe_hit | output | 1 | Lookup hits a valid line |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | ADDR_W | Writeback line address |
| wb_ack | input | 1 | Writeback acknowledge |

## Verification
The properties assume three things about the inputs. `wb_ack` only pulses while `wb_req` is high. Fills never place two identical tags in one set. The allocation path never runs while an operation is in flight. The stimulus respects all three. Every fill gives way w a tag whose low two bits equal w. The bench's writeback responder acknowledges only a request it has seen, and only after a random delay. Fills are issued only after the stall output has dropped. The one deliberate stall test drives a control write against a held writeback and releases it before acknowledging.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
   typedef enum logic [2:0] {
      SEL_CTRL       = 3'd0,
      SEL_LINE_INV   = 3'd1,
      SEL_LINE_FLUSH = 3'd2,
      SEL_ALL_INV    = 3'd3,
      SEL_ALL_FLUSH  = 3'd4
   } reg_sel_e;

   // bit 0: line leaves the array, bit 1: dirty data is written back
   typedef enum logic [1:0] {
      COP_NONE      = 2'd0,
      COP_INV       = 2'd1,
      COP_FLUSH     = 2'd2,
      COP_FLUSH_INV = 2'd3
   } cop_e;

   typedef enum logic [1:0] {
      EST_IDLE = 2'd0,
      EST_LOOK = 2'd1,
      EST_WALK = 2'd2,
      EST_WB   = 2'd3
   } eng_st_e;
endpackage

// File: rtl/dcm_regs.sv
module dcm_regs import dcm_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int OFS_W      = 5,
   parameter int IDX_W      = 6,
   parameter int TAG_W      = 21,
   parameter int ALIAS_BITS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aux_wr,
   input  logic              aux_rd,
   input  logic [2:0]        aux_addr,
   input  logic [ADDR_W-1:0] aux_wdata,
   output logic [ADDR_W-1:0] aux_rdata,
   input  logic              stall,
   input  logic              flush_busy,
   output logic              cache_dis,
   output logic              inv_mode,
   output logic              cmd_valid,
   output cop_e              cmd_op,
   output logic              cmd_all,
   output logic [IDX_W-1:0]  cmd_set,
   output logic [TAG_W-1:0]  cmd_tag
);
   logic wr_ok;
   logic dis_q, mode_q;

   assign wr_ok     = aux_wr && !stall;
   assign cache_dis = dis_q;
   assign inv_mode  = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q  <= 1'b0;
         mode_q <= 1'b0;
      end else if (wr_ok && reg_sel_e'(aux_addr) == SEL_CTRL) begin
         dis_q  <= aux_wdata[0];
         mode_q <= aux_wdata[1];
      end
   end

   always_comb begin
      cmd_valid = 1'b0;
      cmd_all   = 1'b0;
      cmd_op    = COP_NONE;
      case (reg_sel_e'(aux_addr))
         SEL_LINE_INV: begin
            cmd_valid = wr_ok;
            cmd_op    = mode_q ? COP_FLUSH_INV : COP_INV;
         end
         SEL_LINE_FLUSH: begin
            cmd_valid = wr_ok;
            cmd_op    = COP_FLUSH;
         end
         SEL_ALL_INV: begin
            cmd_valid = wr_ok && aux_wdata[0];
            cmd_all   = 1'b1;
            cmd_op    = mode_q ? COP_FLUSH_INV : COP_INV;
         end
         SEL_ALL_FLUSH: begin
            cmd_valid = wr_ok && aux_wdata[0];
            cmd_all   = 1'b1;
            cmd_op    = COP_FLUSH;
         end
         default: ;
      endcase
   end

   assign cmd_tag = aux_wdata[ADDR_W-1 -: TAG_W];

   // top index bits either come from the physical address or ride in the offset field
   if (ALIAS_BITS == 0) begin : g_pidx
      assign cmd_set = aux_wdata[OFS_W +: IDX_W];
   end else begin : g_vidx
      assign cmd_set = {aux_wdata[ALIAS_BITS-1:0], aux_wdata[OFS_W +: (IDX_W-ALIAS_BITS)]};
   end

   assign aux_rdata = (aux_rd && reg_sel_e'(aux_addr) == SEL_CTRL)
                      ? ADDR_W'({flush_busy, mode_q, dis_q}) : '0;
endmodule

// File: rtl/dcm_tag_array.sv
module dcm_tag_array #(
   parameter int SETS  = 64,
   parameter int WAYS  = 4,
   parameter int TAG_W = 21,
   parameter int IDX_W = 6,
   parameter int WAY_W = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IDX_W-1:0]            rd_set,
   output logic [WAYS-1:0]             rd_val,
   output logic [WAYS-1:0]             rd_dirty,
   output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
   input  logic [IDX_W-1:0]            pr_set,
   input  logic [TAG_W-1:0]            pr_tag,
   output logic                        pr_hit,
   input  logic                        upd_en,
   input  logic [IDX_W-1:0]            upd_set,
   input  logic [WAY_W-1:0]            upd_way,
   input  logic                        upd_val,
   input  logic                        upd_dirty,
   input  logic                        fill_en,
   input  logic [IDX_W-1:0]            fill_set,
   input  logic [WAY_W-1:0]            fill_way,
   input  logic [TAG_W-1:0]            fill_tag,
   input  logic                        fill_dirty
);
   logic [WAYS-1:0]  val_q   [SETS];
   logic [WAYS-1:0]  dirty_q [SETS];
   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic [WAYS-1:0]  pr_match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            val_q[s]   <= '0;
            dirty_q[s] <= '0;
         end
      end else if (upd_en) begin
         val_q[upd_set][upd_way]   <= upd_val;
         dirty_q[upd_set][upd_way] <= upd_dirty;
      end else if (fill_en) begin
         val_q[fill_set][fill_way]   <= 1'b1;
         dirty_q[fill_set][fill_way] <= fill_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en && !upd_en) tag_q[fill_set][fill_way] <= fill_tag;
   end

   assign rd_val   = val_q[rd_set];
   assign rd_dirty = dirty_q[rd_set];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign rd_tag[w]   = tag_q[rd_set][w];
      assign pr_match[w] = val_q[pr_set][w] && (tag_q[pr_set][w] == pr_tag);
   end

   assign pr_hit = |pr_match;
endmodule

// File: rtl/dcm_engine.sv
module dcm_engine import dcm_pkg::*; #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 5,
   parameter int IDX_W  = 6,
   parameter int TAG_W  = 21,
   parameter int WAYS   = 4,
   parameter int WAY_W  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid,
   input  cop_e                        cmd_op,
   input  logic                        cmd_all,
   input  logic [IDX_W-1:0]            cmd_set,
   input  logic [TAG_W-1:0]            cmd_tag,
   output logic [IDX_W-1:0]            rd_set,
   input  logic [WAYS-1:0]             rd_val,
   input  logic [WAYS-1:0]             rd_dirty,
   input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
   output logic                        upd_en,
   output logic [IDX_W-1:0]            upd_set,
   output logic [WAY_W-1:0]            upd_way,
   output logic                        upd_val,
   output logic                        upd_dirty,
   output logic                        wb_req,
   output logic [ADDR_W-1:0]           wb_addr,
   input  logic                        wb_ack,
   output logic                        busy,
   output logic                        flush_busy
);
   localparam int POS_W = IDX_W + WAY_W;

   eng_st_e          st_q, st_d;
   cop_e             op_q, op_d;
   logic             all_q, all_d;
   logic [IDX_W-1:0] set_q, set_d;
   logic [WAY_W-1:0] way_q, way_d;
   logic [TAG_W-1:0] tag_q, tag_d;

   logic [WAYS-1:0]  hit_vec;
   logic             hit_any;
   logic [WAY_W-1:0] hit_way, sel_way;
   logic             wants_wb, drops, last;
   logic [POS_W-1:0] pos_nx;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = rd_val[w] && (rd_tag[w] == tag_q);
   end

   always_comb begin
      hit_way = '0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

   assign hit_any  = |hit_vec;
   assign wants_wb = op_q[1];
   assign drops    = op_q[0];
   assign sel_way  = (st_q == EST_LOOK) ? hit_way : way_q;
   assign last     = (&set_q) && (&way_q);
   assign pos_nx   = {set_q, way_q} + POS_W'(1);

   always_comb begin
      st_d      = st_q;
      op_d      = op_q;
      all_d     = all_q;
      set_d     = set_q;
      way_d     = way_q;
      tag_d     = tag_q;
      upd_en    = 1'b0;
      upd_val   = 1'b0;
      upd_dirty = 1'b0;
      case (st_q)
         EST_IDLE: begin
            if (cmd_valid) begin
               op_d  = cmd_op;
               all_d = cmd_all;
               set_d = cmd_all ? '0 : cmd_set;
               way_d = '0;
               tag_d = cmd_tag;
               st_d  = cmd_all ? EST_WALK : EST_LOOK;
            end
         end
         EST_LOOK: begin
            if (!hit_any) begin
               st_d = EST_IDLE;
            end else begin
               way_d = hit_way;
               if (wants_wb && rd_dirty[hit_way]) begin
                  st_d = EST_WB;
               end else begin
                  upd_en = drops;
                  st_d   = EST_IDLE;
               end
            end
         end
         EST_WALK: begin
            if (wants_wb && rd_val[way_q] && rd_dirty[way_q]) begin
               st_d = EST_WB;
            end else begin
               upd_en = drops && rd_val[way_q];
               {set_d, way_d} = pos_nx;
               if (last) st_d = EST_IDLE;
            end
         end
         EST_WB: begin
            if (wb_ack) begin
               upd_en  = 1'b1;
               upd_val = !drops;
               if (all_q && !last) begin
                  {set_d, way_d} = pos_nx;
                  st_d = EST_WALK;
               end else begin
                  st_d = EST_IDLE;
               end
            end
         end
         default: st_d = EST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= EST_IDLE;
         op_q  <= COP_NONE;
         all_q <= 1'b0;
         set_q <= '0;
         way_q <= '0;
         tag_q <= '0;
      end else begin
         st_q  <= st_d;
         op_q  <= op_d;
         all_q <= all_d;
         set_q <= set_d;
         way_q <= way_d;
         tag_q <= tag_d;
      end
   end

   assign rd_set     = set_q;
   assign upd_set    = set_q;
   assign upd_way    = sel_way;
   assign wb_req     = (st_q == EST_WB);
   assign wb_addr    = {rd_tag[way_q], set_q, {OFS_W{1'b0}}};
   assign busy       = (st_q != EST_IDLE);
   assign flush_busy = busy && op_q[1];
endmodule

// File: rtl/dcache_maint_ctrl.sv
module dcache_maint_ctrl import dcm_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int SETS       = 64,
   parameter int WAYS       = 4,
   parameter int ALIAS_BITS = 1,
   // derived widths, not meant to be overridden
   parameter int OFS_W      = $clog2(LINE_BYTES),
   parameter int IDX_W      = $clog2(SETS),
   parameter int WAY_W      = $clog2(WAYS),
   parameter int TAG_W      = ADDR_W - IDX_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aux_wr,
   input  logic              aux_rd,
   input  logic [2:0]        aux_addr,
   input  logic [ADDR_W-1:0] aux_wdata,
   output logic [ADDR_W-1:0] aux_rdata,
   output logic              aux_stall,
   output logic              cache_en,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_set,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic              fill_dirty,
   input  logic [IDX_W-1:0]  probe_set,
   input  logic [TAG_W-1:0]  probe_tag,
   output logic              probe_hit,
   output logic              wb_req,
   output logic [ADDR_W-1:0] wb_addr,
   input  logic              wb_ack
);
   initial begin : elab_chk
      assert (LINE_BYTES == (1 << OFS_W)) else $fatal(1, "line size must be a power of two");
      assert (SETS == (1 << IDX_W))       else $fatal(1, "set count must be a power of two");
      assert (WAYS >= 2 && WAYS == (1 << WAY_W)) else $fatal(1, "way count must be a power of two >= 2");
      assert (ALIAS_BITS >= 0 && ALIAS_BITS <= OFS_W && ALIAS_BITS < IDX_W)
         else $fatal(1, "alias bits must fit the offset and index fields");
      assert (TAG_W > 0) else $fatal(1, "address too narrow");
   end

   logic                       cache_dis, inv_mode;
   logic                       cmd_valid, cmd_all;
   cop_e                       cmd_op;
   logic [IDX_W-1:0]           cmd_set, rd_set, upd_set;
   logic [TAG_W-1:0]           cmd_tag;
   logic [WAYS-1:0]            rd_val, rd_dirty;
   logic [WAYS-1:0][TAG_W-1:0] rd_tag;
   logic                       upd_en, upd_val, upd_dirty;
   logic [WAY_W-1:0]           upd_way;
   logic                       eng_busy, eng_flush_busy, arr_hit;

   dcm_regs #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ALIAS_BITS(ALIAS_BITS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .aux_wr(aux_wr), .aux_rd(aux_rd), .aux_addr(aux_addr), .aux_wdata(aux_wdata),
      .aux_rdata(aux_rdata), .stall(eng_busy), .flush_busy(eng_flush_busy),
      .cache_dis(cache_dis), .inv_mode(inv_mode),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_all(cmd_all),
      .cmd_set(cmd_set), .cmd_tag(cmd_tag)
   );

   dcm_engine #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAYS(WAYS), .WAY_W(WAY_W)
   ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_all(cmd_all),
      .cmd_set(cmd_set), .cmd_tag(cmd_tag),
      .rd_set(rd_set), .rd_val(rd_val), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
      .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way),
      .upd_val(upd_val), .upd_dirty(upd_dirty),
      .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
      .busy(eng_busy), .flush_busy(eng_flush_busy)
   );

   dcm_tag_array #(
      .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
   ) u_arr (
      .clk(clk), .rst_n(rst_n),
      .rd_set(rd_set), .rd_val(rd_val), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
      .pr_set(probe_set), .pr_tag(probe_tag), .pr_hit(arr_hit),
      .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way),
      .upd_val(upd_val), .upd_dirty(upd_dirty),
      .fill_en(fill_en && !cache_dis && !eng_busy),
      .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag), .fill_dirty(fill_dirty)
   );

   assign aux_stall = eng_busy;
   assign cache_en  = !cache_dis;
   assign probe_hit = arr_hit && !cache_dis;
endmodule

// File: rtl/dcache_maint_chk.sv
module dcache_maint_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wb_req,
   input logic              wb_ack,
   input logic [ADDR_W-1:0] wb_addr,
   input logic              aux_stall,
   input logic              flush_busy,
   input logic              inv_mode,
   input logic              cache_en,
   input logic              probe_hit
);
   AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && !wb_ack |=> wb_req && $stable(wb_addr)); // R11
   AST_WB_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> flush_busy); // R9
   AST_WB_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> aux_stall); // R10
   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      aux_stall |=> $stable(inv_mode)); // R10
   AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !cache_en |-> !probe_hit); // R12
endmodule

bind dcache_maint_ctrl dcache_maint_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wb_req(wb_req), .wb_ack(wb_ack), .wb_addr(wb_addr),
   .aux_stall(aux_stall), .flush_busy(eng_flush_busy), .inv_mode(inv_mode),
   .cache_en(cache_en), .probe_hit(probe_hit)
);

// File: tb/dcache_maint_ctrl_tb.sv
module dcache_maint_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NSETS = 64;
   localparam int NWAYS = 4;
   localparam int NLINES = NSETS * NWAYS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        aux_wr = 1'b0, aux_rd = 1'b0;
   logic [2:0]  aux_addr = '0;
   logic [31:0] aux_wdata = '0;
   logic [31:0] aux_rdata;
   logic        aux_stall, cache_en;
   logic        fill_en = 1'b0, fill_dirty = 1'b0;
   logic [5:0]  fill_set = '0, probe_set = '0;
   logic [1:0]  fill_way = '0;
   logic [20:0] fill_tag = '0, probe_tag = '0;
   logic        probe_hit, wb_req, wb_ack;
   logic [31:0] wb_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   dcache_maint_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .aux_wr(aux_wr), .aux_rd(aux_rd), .aux_addr(aux_addr),
      .aux_wdata(aux_wdata), .aux_rdata(aux_rdata), .aux_stall(aux_stall), .cache_en(cache_en),
      .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
      .fill_dirty(fill_dirty), .probe_set(probe_set), .probe_tag(probe_tag),
      .probe_hit(probe_hit), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack)
   );

   int n_chk = 0, n_fail = 0;
   bit m_v [NLINES];
   bit m_d [NLINES];
   logic [20:0] m_t [NLINES];
   bit m_en = 1'b1;
   logic [31:0] exp_q [1024];
   logic [31:0] cap_q [1024];
   int exp_n = 0, cap_n = 0;
   bit hold_ack = 1'b0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   // writeback responder: acknowledges each request after a random delay
   initial begin
      wb_ack = 1'b0;
      forever begin
         @(negedge clk);
         wb_ack = 1'b0;
         if (wb_req) begin
            while (hold_ack) @(negedge clk);
            repeat ($urandom % 3) @(negedge clk);
            if (cap_n < 1024) cap_q[cap_n] = wb_addr;
            cap_n++;
            wb_ack = 1'b1;
         end
      end
   end

   function automatic logic [31:0] cmd_addr(input int s, input logic [20:0] t);
      logic [31:0] a;
      a = $urandom;
      a[31:11] = t;
      a[9:5]   = s[4:0];
      a[0]     = s[5];
      return a;
   endfunction

   function automatic logic [31:0] line_addr(input int s, input logic [20:0] t);
      return {t, s[5:0], 5'b0};
   endfunction

   task automatic push_exp(input int s, input logic [20:0] t);
      exp_q[exp_n] = line_addr(s, t);
      exp_n++;
   endtask

   // op: 1 discard, 2 flush, 3 write back then discard
   task automatic model_entry(input int idx, input int op);
      if (m_v[idx]) begin
         if (op[1] && m_d[idx]) push_exp(idx / NWAYS, m_t[idx]);
         if (op[1]) m_d[idx] = 1'b0;
         if (op[0]) begin m_v[idx] = 1'b0; m_d[idx] = 1'b0; end
      end
   endtask

   task automatic model_line(input int s, input logic [20:0] t, input int op);
      for (int w = 0; w < NWAYS; w++) begin
         if (m_v[s*NWAYS+w] && m_t[s*NWAYS+w] == t) begin
            model_entry(s*NWAYS+w, op);
            return;
         end
      end
   endtask

   task automatic aux_write(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      aux_wr = 1'b1; aux_addr = sel; aux_wdata = d;
      while (aux_stall) @(negedge clk);
      @(negedge clk);
      aux_wr = 1'b0;
   endtask

   task automatic aux_read(input logic [2:0] sel, output logic [31:0] d);
      @(negedge clk);
      aux_addr = sel; aux_rd = 1'b1;
      #1 d = aux_rdata;
      aux_rd = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (aux_stall) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic fill(input int s, input int w, input logic [20:0] t, input bit d);
      @(negedge clk);
      fill_en = 1'b1; fill_set = s[5:0]; fill_way = w[1:0]; fill_tag = t; fill_dirty = d;
      @(negedge clk);
      fill_en = 1'b0;
      if (m_en) begin m_v[s*NWAYS+w] = 1'b1; m_d[s*NWAYS+w] = d; m_t[s*NWAYS+w] = t; end
   endtask

   function automatic logic [20:0] rnd_tag(input int w);
      logic [20:0] t;
      t = 21'($urandom);
      t[1:0] = w[1:0];
      return t;
   endfunction

   task automatic fill_all_random();
      for (int s = 0; s < NSETS; s++)
         for (int w = 0; w < NWAYS; w++)
            fill(s, w, rnd_tag(w), 1'($urandom));
   endtask

   task automatic probe_chk(input int s, input logic [20:0] t, input string req);
      bit e;
      e = 1'b0;
      for (int w = 0; w < NWAYS; w++)
         if (m_v[s*NWAYS+w] && m_t[s*NWAYS+w] == t) e = 1'b1;
      e = e && m_en;
      @(negedge clk);
      probe_set = s[5:0]; probe_tag = t;
      #1 chk(probe_hit == e, req, probe_hit, e);
   endtask

   task automatic cmp_wb(input string req);
      chk(cap_n == exp_n, req, cap_n, exp_n);
      for (int i = 0; i < exp_n && i < cap_n; i++)
         chk(cap_q[i] == exp_q[i], req, cap_q[i], exp_q[i]);
      cap_n = 0; exp_n = 0;
   endtask

   task automatic run(input logic [2:0] sel, input logic [31:0] d);
      aux_write(sel, d);
      wait_idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'h1d5c_0a7e));
      for (int i = 0; i < NLINES; i++) begin m_v[i] = 0; m_d[i] = 0; m_t[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      aux_read(3'd0, rd);
      chk(rd == 0, "R1 ctrl", rd, 0);
      chk(wb_req == 0, "R1 wb_req", wb_req, 0);
      probe_chk(0, '0, "R1 probe");
      probe_chk(63, '0, "R1 probe");

      // R2 control register, busy bit read-only
      aux_write(3'd0, 32'h7);
      aux_read(3'd0, rd);
      chk(rd == 32'h3, "R2 ctrl readback", rd, 3);
      chk(cache_en == 0, "R2 cache_en", cache_en, 0);
      aux_write(3'd0, 32'h0);
      chk(cache_en == 1, "R2 cache_en", cache_en, 1);

      fill_all_random();

      // R3 directed: bit 10 and bits [4:1] ignored, bit 0 selects top index bit
      begin
         logic [31:0] a;
         int s;
         s = 37;
         a = cmd_addr(s, m_t[s*NWAYS+1]);
         a[10] = ~a[10]; a[4:1] = ~a[4:1];
         model_line(s, m_t[s*NWAYS+1], 2);
         run(3'd2, a);
         cmp_wb("R3 flush decode");
         probe_chk(s, m_t[s*NWAYS+1], "R3 line kept");
         a = cmd_addr(s, m_t[s*NWAYS+1]);
         a[0] = ~a[0];
         run(3'd1, a);
         cmp_wb("R3 other set");
         probe_chk(s, m_t[s*NWAYS+1], "R3 other set untouched");
      end

      // random line operations: R4 / R5 / R6
      for (int it = 0; it < 120; it++) begin
         int s, w, op;
         logic [20:0] t;
         string tagname;
         s = $urandom % NSETS; w = $urandom % NWAYS;
         t = ($urandom % 4 == 0 || !m_v[s*NWAYS+w]) ? rnd_tag(w) : m_t[s*NWAYS+w];
         op = 1 + ($urandom % 3);
         tagname = (op == 1) ? "R4 line discard" : (op == 2) ? "R6 line flush" : "R5 line wb-discard";
         if (op != 2) aux_write(3'd0, (op == 3) ? 32'h2 : 32'h0);
         model_line(s, t, op);
         run((op == 2) ? 3'd2 : 3'd1, cmd_addr(s, t));
         cmp_wb(tagname);
         probe_chk(s, t, tagname);
         if (!m_v[s*NWAYS+w] && ($urandom % 2 == 0)) fill(s, w, rnd_tag(w), 1'($urandom));
      end

      // R13 whole-cache commands need data bit 0
      run(3'd4, 32'h2);
      run(3'd3, 32'h0);
      cmp_wb("R13 no op");
      for (int s = 0; s < NSETS; s += 9) probe_chk(s, m_t[s*NWAYS+2], "R13 lines kept");

      // R8 whole flush, order, lines stay valid
      for (int i = 0; i < NLINES; i++) model_entry(i, 2);
      run(3'd4, 32'h1);
      cmp_wb("R8 whole flush order");
      for (int s = 0; s < NSETS; s += 5) probe_chk(s, m_t[s*NWAYS+3], "R8 still valid");
      run(3'd4, 32'h1);
      cmp_wb("R8 second flush empty");

      // R7 whole invalidate, mode 1
      fill_all_random();
      aux_write(3'd0, 32'h2);
      for (int i = 0; i < NLINES; i++) model_entry(i, 3);
      run(3'd3, 32'h1);
      cmp_wb("R7 whole wb-discard order");
      for (int s = 0; s < NSETS; s += 7) probe_chk(s, m_t[s*NWAYS], "R7 dropped");

      // R7 whole invalidate, mode 0
      fill_all_random();
      aux_write(3'd0, 32'h0);
      for (int i = 0; i < NLINES; i++) model_entry(i, 1);
      run(3'd3, 32'h1);
      cmp_wb("R7 whole discard no wb");
      for (int s = 1; s < NSETS; s += 7) probe_chk(s, m_t[s*NWAYS+1], "R7 dropped");

      // R12 disable
      fill(7, 0, 21'h0_1230, 1'b0);
      aux_write(3'd0, 32'h1); m_en = 1'b0;
      chk(cache_en == 0, "R12 cache_en", cache_en, 0);
      probe_chk(7, 21'h0_1230, "R12 no hit while off");
      fill(3, 1, 21'h0_4561, 1'b1);
      aux_write(3'd0, 32'h0); m_en = 1'b1;
      probe_chk(7, 21'h0_1230, "R12 hit after enable");
      probe_chk(3, 21'h0_4561, "R12 fill ignored");
      run(3'd4, 32'h1);
      cmp_wb("R12 no dirty from ignored fill");

      // R9 / R10 busy bit and stall with a held writeback
      fill(20, 2, 21'h1_5552, 1'b1);
      hold_ack = 1'b1;
      model_line(20, 21'h1_5552, 2);
      aux_write(3'd2, cmd_addr(20, 21'h1_5552));
      repeat (3) @(negedge clk);
      aux_read(3'd0, rd);
      chk(rd == 32'h4, "R9 busy reads 1", rd, 4);
      chk(aux_stall == 1, "R10 stall high", aux_stall, 1);
      @(negedge clk);
      aux_wr = 1'b1; aux_addr = 3'd0; aux_wdata = 32'h3;
      repeat (3) @(negedge clk);
      aux_wr = 1'b0;
      hold_ack = 1'b0;
      wait_idle();
      aux_read(3'd0, rd);
      chk(rd == 32'h0, "R10 write dropped, R9 busy clear", rd, 0);
      cmp_wb("R11 single writeback");
      probe_chk(20, 21'h1_5552, "R6 flushed line valid");

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule